// File: doc/BRIEF.md
# Coarse/Fine Double-Buffered Pulse Generator

This block produces one pulse train per channel. Both the period and the pulse width are given in units of a fine step, which is a fraction of the fast clock period. The upper bits of each value are counted in whole clock cycles. The low `FW` bits of the width are driven out as a tap code. An external delay line uses that code to move the falling edge by less than one clock period. Each cycle the block produces a coarse rising strobe, a coarse falling strobe and a gated level. The falling strobe comes with its tap code.

Each channel has a shadow set of registers that a host fills through a simple write/read register port. The pulse logic reads only an active set. A channel copies the shadow set into the active set only at a period boundary, so no period mixes two configurations. Two events can request that copy. One is a host write to the period or width register, when the channel's commit-on-write bit is set. The other is a rising edge on that channel's external trigger input, when its trigger-select bit is set. The external input first passes through a two-flop synchroniser and an edge detector.

Top module: `pwm_cf_core`

## Requirements
- R1: After reset every pulse, strobe and tap output is low, and every channel register reads back as zero.
- R2: Register address is {channel, index}. Index 0 is control (bit 0 enable, bit 1 commit-on-write, bit 2 trigger-select, bit 3 read-only pending). Index 1 is period and index 2 is width. Reads return the shadow values.
- R3: The coarse period is the period value shifted right by `FW`. A coarse period of 0 counts as 1, and the low `FW` period bits are ignored. The first enabled cycle is count 0.
- R4: Width W with 0 < W < coarse period·2^FW gives a rise strobe at count 0 and a fall strobe at count W>>FW. The level is high for counts below W>>FW, and also at count W>>FW when the tap is nonzero. The tap equals the low `FW` bits of W all through the period.
- R5: A width of zero keeps the level low with no strobes, and the tap reads 0.
- R6: A width of at least coarse period·2^FW keeps the level high for the whole period with no strobes, and the tap reads 0.
- R7: While enable is clear, the level and both strobes are low, starting from the cycle after the control write.
- R8: A shadow write has no effect on the outputs while no commit is requested, and pending stays 0.
- R9: With commit-on-write set, a period or width write sets pending. All shadow values written before the next period boundary take effect together from that boundary, and pending then clears.
- R10: With trigger-select set, a rising trigger edge sets pending within three cycles, and the shadow values apply at the next boundary.
- R11: With trigger-select clear, trigger edges set no pending and change no output.
- R12: Channels are independent. Writes and enables of one channel leave the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address {channel, index} |
| wr_data_i | input | CW+FW | Write data |
| rd_addr_i | input | AW | Read address {channel, index} |
| rd_data_o | output | CW+FW | Combinational read data |
| ext_trig_i | input | NCH | Asynchronous per-channel commit triggers |
| pwm_o | output | NCH | Coarse pulse level per channel |
| rise_o | output | NCH | Coarse rising-edge strobe |
| fall_o | output | NCH | Coarse falling-edge strobe |
| tap_o | output | NCH·FW | Fine tap code for the falling edge, per channel |

## Verification
The bench builds the block with two channels, an 8-bit coarse count and a 3-bit fine field. With these values a period of a few cycles exercises every width mode in a short run. Fine offsets of 0 and of nonzero values show both gate shapes at the falling strobe. The second channel makes it possible to show that one channel's writes and trigger leave the other untouched. Period lengths of one, two and several coarse cycles cover the wrap point and the boundary-only commit.

// File: rtl/pwm_cf_pkg.sv
package pwm_cf_pkg;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_PER  = 2'd1;
    localparam logic [1:0] REG_WID  = 2'd2;

    localparam int CB_EN   = 0;
    localparam int CB_COW  = 1;
    localparam int CB_TSEL = 2;

    typedef enum logic [1:0] {
        M_OFF  = 2'd0,
        M_NORM = 2'd1,
        M_FULL = 2'd2
    } pmode_e;
endpackage

// File: rtl/pwm_cf_trig_sync.sv
module pwm_cf_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-1:0], async_i};
        rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/pwm_cf_channel.sv
module pwm_cf_channel
    import pwm_cf_pkg::*;
#(
    parameter int CW = 8,
    parameter int FW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_idx_i,
    input  logic [CW+FW-1:0] wr_data_i,
    input  logic [1:0]       rd_idx_i,
    output logic [CW+FW-1:0] rd_data_o,
    input  logic             trig_i,
    output logic             pwm_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic [FW-1:0]    tap_o,
    output logic             en_o,
    output logic             pend_o,
    output logic             bnd_o
);
    localparam int VW = CW + FW;

    typedef struct packed {
        logic [2:0]    ctrl;
        logic          pend;
        logic [VW-1:0] sh_per;
        logic [VW-1:0] sh_wid;
        logic [VW-1:0] ac_per;
        logic [VW-1:0] ac_wid;
        logic [CW-1:0] cnt;
    } chan_st_t;

    chan_st_t      s_d, s_q;
    logic [CW-1:0] pc, pe, last, wc;
    logic [FW-1:0] wf;
    logic          en, bnd, arm;
    pmode_e        mode;

    always_comb begin
        pc   = s_q.ac_per[VW-1:FW];
        pe   = (pc == '0) ? CW'(1) : pc;
        last = pe - CW'(1);
        wc   = s_q.ac_wid[VW-1:FW];
        wf   = s_q.ac_wid[FW-1:0];
        en   = s_q.ctrl[CB_EN];
        bnd  = !en || (s_q.cnt == last);

        if (s_q.ac_wid == '0)  mode = M_OFF;
        else if (wc >= pe)     mode = M_FULL;
        else                   mode = M_NORM;

        arm = (wr_en_i && s_q.ctrl[CB_COW] &&
               (wr_idx_i == REG_PER || wr_idx_i == REG_WID)) ||
              (trig_i && s_q.ctrl[CB_TSEL]);

        s_d = s_q;
        if (wr_en_i) begin
            case (wr_idx_i)
                REG_CTRL: s_d.ctrl   = wr_data_i[2:0];
                REG_PER:  s_d.sh_per = wr_data_i;
                REG_WID:  s_d.sh_wid = wr_data_i;
                default:  ;
            endcase
        end

        if (!en)                 s_d.cnt = '0;
        else if (s_q.cnt == last) s_d.cnt = '0;
        else                     s_d.cnt = s_q.cnt + CW'(1);

        if (s_q.pend && bnd) begin
            s_d.ac_per = s_q.sh_per;
            s_d.ac_wid = s_q.sh_wid;
        end
        s_d.pend = arm || (s_q.pend && !bnd);

        rise_o = en && (mode == M_NORM) && (s_q.cnt == '0);
        fall_o = en && (mode == M_NORM) && (s_q.cnt == wc);
        pwm_o  = en && ((mode == M_FULL) ||
                        ((mode == M_NORM) &&
                         ((s_q.cnt < wc) || ((s_q.cnt == wc) && (wf != '0)))));
        tap_o  = (mode == M_NORM) ? wf : '0;
        en_o   = en;
        pend_o = s_q.pend;
        bnd_o  = bnd;

        case (rd_idx_i)
            REG_CTRL: rd_data_o = VW'({s_q.pend, s_q.ctrl});
            REG_PER:  rd_data_o = s_q.sh_per;
            REG_WID:  rd_data_o = s_q.sh_wid;
            default:  rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_cf_core.sv
module pwm_cf_core #(
    parameter int NCH = 2,
    parameter int CW  = 8,
    parameter int FW  = 3,
    localparam int VW  = CW + FW,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW  = CHW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [VW-1:0]     wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [VW-1:0]     rd_data_o,
    input  logic [NCH-1:0]    ext_trig_i,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH-1:0]    rise_o,
    output logic [NCH-1:0]    fall_o,
    output logic [NCH*FW-1:0] tap_o
);
    logic [VW-1:0]  rd_arr [NCH];
    logic [NCH-1:0] ch_en, ch_pend, ch_bnd, ch_trig;
    logic [CHW-1:0] rd_ch;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_cf_trig_sync #(.STAGES(2)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ext_trig_i[g]),
            .rise_o  (ch_trig[g])
        );

        pwm_cf_channel #(.CW(CW), .FW(FW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en_i && (wr_addr_i[AW-1:2] == CHW'(g))),
            .wr_idx_i  (wr_addr_i[1:0]),
            .wr_data_i (wr_data_i),
            .rd_idx_i  (rd_addr_i[1:0]),
            .rd_data_o (rd_arr[g]),
            .trig_i    (ch_trig[g]),
            .pwm_o     (pwm_o[g]),
            .rise_o    (rise_o[g]),
            .fall_o    (fall_o[g]),
            .tap_o     (tap_o[g*FW +: FW]),
            .en_o      (ch_en[g]),
            .pend_o    (ch_pend[g]),
            .bnd_o     (ch_bnd[g])
        );
    end

    always_comb begin
        rd_ch     = rd_addr_i[AW-1:2];
        rd_data_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_ch == CHW'(c)) rd_data_o = rd_arr[c];
        end
    end
endmodule

// File: rtl/pwm_cf_core_chk.sv
module pwm_cf_core_chk #(
    parameter int NCH = 2,
    parameter int FW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    pwm_o,
    input logic [NCH-1:0]    rise_o,
    input logic [NCH-1:0]    fall_o,
    input logic [NCH*FW-1:0] tap_o,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    ch_pend,
    input logic [NCH-1:0]    ch_bnd
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R4
        rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |-> pwm_o[i]);

        // R4
        fall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o[i] |-> (pwm_o[i] == (tap_o[i*FW +: FW] != '0)));

        // R7
        off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> !(pwm_o[i] || rise_o[i] || fall_o[i]));

        // R9
        commit_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_pend[i]) |-> $past(ch_bnd[i]));

        // R8
        tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(ch_bnd[i]) |-> $stable(tap_o[i*FW +: FW]));
    end
endmodule

bind pwm_cf_core pwm_cf_core_chk #(.NCH(NCH), .FW(FW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_o   (pwm_o),
    .rise_o  (rise_o),
    .fall_o  (fall_o),
    .tap_o   (tap_o),
    .ch_en   (ch_en),
    .ch_pend (ch_pend),
    .ch_bnd  (ch_bnd)
);

// File: tb/pwm_cf_core_test.sv
module pwm_cf_core_test;
    localparam int NCH = 2;
    localparam int CW  = 8;
    localparam int FW  = 3;
    localparam int VW  = CW + FW;
    localparam int AW  = 3;
    localparam int NV  = 10;
    localparam int VEC [NV][2] = '{
        '{40, 19}, '{40, 0}, '{40, 40}, '{40, 64}, '{16, 5},
        '{8, 3},   '{24, 16}, '{0, 0},  '{80, 33}, '{40, 19}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [VW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [VW-1:0]   rd_data;
    logic [NCH-1:0]  ext = '0;
    logic [NCH-1:0]  pwm, rise, fall;
    logic [NCH*FW-1:0] tap;

    int nvec = 0, nerr = 0;
    bit done = 0;
    int cP[NCH], cW[NCH], ph[NCH], nP[NCH], nW[NCH];
    bit en_m[NCH], pend_m[NCH];
    string note = "";

    always #10 clk = ~clk;

    pwm_cf_core #(.NCH(NCH), .CW(CW), .FW(FW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ext_trig_i(ext), .pwm_o(pwm), .rise_o(rise), .fall_o(fall), .tap_o(tap)
    );

    function automatic int pe_of(int p);
        int v = p >> FW;
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            int pe = pe_of(cP[c]);
            int wc = cW[c] >> FW;
            int wf = cW[c] & ((1 << FW) - 1);
            bit e_pw = 0, e_ri = 0, e_fa = 0;
            int e_tp = 0;
            string tg;
            if (cW[c] == 0) tg = "R5";
            else if (wc >= pe) begin tg = "R6"; e_pw = 1; end
            else begin
                tg = "R3 R4"; e_tp = wf;
                e_ri = (ph[c] == 0);
                e_fa = (ph[c] == wc);
                e_pw = (ph[c] < wc) || (ph[c] == wc && wf != 0);
            end
            if (!en_m[c]) begin tg = "R7"; e_pw = 0; e_ri = 0; e_fa = 0; end
            nvec++;
            if (pwm[c] !== e_pw || rise[c] !== e_ri || fall[c] !== e_fa ||
                tap[c*FW +: FW] !== FW'(e_tp)) begin
                nerr++;
                $display("FAIL %s %s ch%0d ph%0d: got pwm=%b rise=%b fall=%b tap=%0d exp pwm=%b rise=%b fall=%b tap=%0d",
                         tg, note, c, ph[c], pwm[c], rise[c], fall[c], tap[c*FW +: FW],
                         e_pw, e_ri, e_fa, e_tp);
            end
        end
    endtask

    task automatic advance();
        for (int c = 0; c < NCH; c++) begin
            if (!en_m[c]) ph[c] = 0;
            else if (ph[c] == pe_of(cP[c]) - 1) begin
                ph[c] = 0;
                if (pend_m[c]) begin cP[c] = nP[c]; cW[c] = nW[c]; pend_m[c] = 0; end
            end else ph[c]++;
        end
    endtask

    task automatic step();
        @(negedge clk);
        wr_en = 1'b0;
        check_all();
        advance();
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic step_wr(logic [AW-1:0] a, int d);
        @(negedge clk);
        check_all();
        wr_en = 1'b1; wr_addr = a; wr_data = VW'(d);
        advance();
    endtask

    task automatic wait_ph0();
        while (ph[0] != 0) step();
    endtask

    task automatic rd_chk(logic [AW-1:0] a, int expv, string tg);
        rd_addr = a;
        #1;
        nvec++;
        if (rd_data !== VW'(expv)) begin
            nerr++;
            $display("FAIL %s read addr %0d: got %0d exp %0d", tg, a, rd_data, expv);
        end
    endtask

    task automatic load(int c, int p, int w);
        logic [AW-1:0] b = AW'(c * 4);
        step_wr(b, 2); en_m[c] = 0; ph[c] = 0;
        step_wr(b + 1, p);
        step_wr(b + 2, w);
        cP[c] = p; step();
        cW[c] = w; step();
        step_wr(b, 3); en_m[c] = 1; ph[c] = 0;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            cP[c] = 0; cW[c] = 0; ph[c] = 0; en_m[c] = 0; pend_m[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        note = "R1";
        step();
        rd_chk(0, 0, "R1"); rd_chk(1, 0, "R1"); rd_chk(2, 0, "R1");

        // vector table walk
        note = "";
        for (int v = 0; v < NV; v++) begin
            load(0, VEC[v][0], VEC[v][1]);
            steps(2 * pe_of(VEC[v][0]) + 2);
        end
        rd_chk(1, 40, "R2"); rd_chk(2, 19, "R2"); rd_chk(0, 3, "R2");

        // R8: shadow write without commit
        step_wr(0, 1);
        wait_ph0();
        step_wr(2, 8);
        note = "R8"; steps(10);
        rd_chk(2, 8, "R2"); rd_chk(0, 1, "R8");

        // R11: trigger ignored without select
        step_wr(0, 3);
        wait_ph0();
        ext[0] = 1'b1; steps(2); ext[0] = 1'b0; steps(4);
        rd_chk(0, 3, "R11");
        note = "R11"; steps(10);

        // R10: trigger with select commits at next boundary
        step_wr(0, 5);
        steps(6);
        wait_ph0();
        ext[0] = 1'b1; pend_m[0] = 1; nP[0] = 40; nW[0] = 8;
        note = "R10"; steps(3);
        rd_chk(0, 13, "R10");
        ext[0] = 1'b0;
        steps(10);
        rd_chk(0, 5, "R10");

        // R9: commit-on-write, two writes in one period apply together
        step_wr(0, 3);
        wait_ph0();
        step_wr(1, 48); pend_m[0] = 1; nP[0] = 48; nW[0] = 8;
        step_wr(2, 21); nW[0] = 21;
        rd_chk(0, 11, "R9");
        note = "R9"; steps(14);
        rd_chk(0, 3, "R9");

        // R12: second channel independent of first
        step_wr(0, 0); en_m[0] = 0; ph[0] = 0;
        note = "R12";
        load(1, 16, 5);
        steps(6);
        rd_chk(2, 21, "R12"); rd_chk(1, 48, "R12");
        rd_chk(5, 16, "R12"); rd_chk(6, 5, "R12");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog (all R checks): got hang exp finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule